// File: doc/BRIEF.md
# Parking Bus Arbiter

This block decides which of several bus masters owns a shared bus. Each master raises its own request line. The arbiter drives a one-hot set of grant lines. All requests are looked at in parallel on every rising clock edge.

The arbiter picks the next owner while the current transaction is still running. Moving a grant away from a master tells that master to finish its burst. The newly granted master waits for the bus-idle input before it starts. The arbiter then holds that grant until the new owner has really taken the bus, or until it withdraws its request. When no other master is asking, the grant stays parked on the last owner. That owner can then start again at once, without a new arbitration.

Fairness is round-robin. The search starts just after the current holder, and the holder itself comes last.

Top module: `park_arb`

## Requirements
- R1: While reset is active, and on the first edge after it, the grant is parked on master 0 (gnt equals 1) and the arbiter is free to arbitrate.
- R2: The grant output always has exactly one bit set, and bit i means master i holds the grant.
- R3: While the arbiter is free, if no master other than the grant holder requests, the grant is unchanged after the next edge, whether the holder requests or not.
- R4: While the arbiter is free, if any other master requests, the grant moves after the next edge to the first requester found in the order holder+1, holder+2, and so on, wrapping modulo the master count. The holder is not considered.
- R5: The decision in R4 is independent of bus_idle, so a hand-over is decided while the bus is still busy.
- R6: After the grant moves, it stays unchanged until the hand-over completes (R8) or is abandoned (R7), whatever the other masters request.
- R7: If the new holder's request is low at an edge during a hand-over, the arbiter becomes free at that edge. It may move the grant at the following edge.
- R8: A hand-over completes when bus_idle has been sampled high and then, at a later edge, sampled low while the holder still requests. The arbiter is free after that second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | One request line per master |
| bus_idle | input | 1 | High when no transaction is on the bus |
| gnt | output | N | One-hot grant lines |

## Verification
The bench sweeps every holder position against every request pattern, with the bus both busy and idle. An arbiter with an off-by-one rotation, or one that let the holder win, would pick the wrong master. A design that waited for the bus to go idle before choosing would lose the overlap. A separate sequence offers competing requests during a hand-over. A design without the hold would bounce the grant away before the new owner ever started, and one that never released on a withdrawn request would keep the bus parked on a master that no longer wants it. A long pseudo-random run is compared, cycle by cycle, with an arithmetic model of the requirements.

// File: rtl/park_arb.sv
module park_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         bus_idle,
  output logic [N-1:0] gnt
);

  typedef enum logic [1:0] {FREE, WAIT_IDLE, WAIT_START} phase_t;

  phase_t       ph;
  logic [IW-1:0] own, win;
  logic          any_other;

  always_comb begin
    own = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) own = IW'(i);
  end

  always_comb begin
    int j;
    win = own;
    any_other = 1'b0;
    for (int k = N - 1; k >= 1; k--) begin
      j = int'(own) + k;
      if (j >= N) j = j - N;
      if (req[j]) begin
        win = IW'(j);
        any_other = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt <= N'(1);
      ph  <= FREE;
    end else begin
      case (ph)
        FREE:
          if (any_other) begin
            gnt <= N'(1) << win;
            ph  <= WAIT_IDLE;
          end
        WAIT_IDLE:
          if (!req[own])    ph <= FREE;
          else if (bus_idle) ph <= WAIT_START;
        default:
          if (!req[own] || !bus_idle) ph <= FREE;
      endcase
    end
  end

  // R1
  reset_park_chk: assert property (@(posedge clk) $rose(rst_n) |-> gnt == N'(1));

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(gnt));

  // R3
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == FREE && (req & ~gnt) == '0) |=> $stable(gnt));

  // R4
  move_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == FREE && (req & ~gnt) != '0) |=> (gnt != $past(gnt)) && ((gnt & $past(req)) != '0));

  // R6
  handover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != FREE) |=> $stable(gnt));

endmodule

// File: tb/park_arb_tb_top.sv
module park_arb_tb_top;
  localparam int N = 4;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [N-1:0] req = '0;
  logic         bus_idle = 1'b1;
  logic [N-1:0] gnt;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] mgnt;
  int           mph;

  always #2 clk = ~clk;

  park_arb #(.N(N)) dut_i (.clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle), .gnt(gnt));

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [N-1:0] g);
    int r = 0;
    for (int i = 0; i < N; i++) if (g[i]) r = i;
    return r;
  endfunction

  function automatic logic [N-1:0] rr_pick(input int h, input logic [N-1:0] r);
    for (int k = 1; k < N; k++)
      if (r[(h + k) % N]) return N'(1) << ((h + k) % N);
    return N'(1) << h;
  endfunction

  task automatic model(input logic [N-1:0] r, input logic idle);
    int h = idx_of(mgnt);
    case (mph)
      0: if ((r & ~mgnt) != 0) begin mgnt = rr_pick(h, r); mph = 1; end
      1: if (!r[h]) mph = 0; else if (idle) mph = 2;
      default: if (!r[h] || !idle) mph = 0;
    endcase
  endtask

  task automatic step(input logic [N-1:0] r, input logic idle);
    @(negedge clk);
    req = r;
    bus_idle = idle;
    model(r, idle);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = '0; bus_idle = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mgnt = N'(1); mph = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    #1;
    check("R1 reset park", gnt, 4'b0001);
    step(4'b0000, 1'b0);
    check("R1 first edge after reset", gnt, 4'b0001);

    for (int h = 0; h < N; h++)
      for (int p = 0; p < 16; p++)
        for (int id = 0; id < 2; id++) begin
          logic [N-1:0] oth, exp;
          do_reset();
          if (h != 0) begin
            step(N'(1) << h, 1'b1);
            step(N'(1) << h, 1'b1);
            step(N'(1) << h, 1'b0);
            check("R8 holder placed", gnt, N'(1) << h);
          end
          step(N'(p), id[0]);
          oth = N'(p) & ~(N'(1) << h);
          exp = (oth == 0) ? (N'(1) << h) : rr_pick(h, N'(p));
          if (oth == 0) check("R3 park", gnt, exp);
          else if (id == 0) check("R5 R4 busy decision", gnt, exp);
          else check("R4 round robin", gnt, exp);
        end

    do_reset();
    step(4'b0010, 1'b0);
    check("R4 move to m1", gnt, 4'b0010);
    step(4'b1110, 1'b0);
    check("R6 hold while busy", gnt, 4'b0010);
    step(4'b1110, 1'b1);
    check("R6 hold at idle", gnt, 4'b0010);
    step(4'b1110, 1'b1);
    check("R6 hold waiting start", gnt, 4'b0010);
    step(4'b1110, 1'b0);
    check("R8 start edge keeps grant", gnt, 4'b0010);
    step(4'b1110, 1'b0);
    check("R8 free after start", gnt, 4'b0100);

    do_reset();
    step(4'b0010, 1'b0);
    step(4'b1000, 1'b0);
    check("R7 withdrawal edge", gnt, 4'b0010);
    step(4'b1000, 1'b0);
    check("R7 rearbitrate", gnt, 4'b1000);

    do_reset();
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] | (lfsr[11] ? mgnt : 4'b0000), lfsr[8]);
      check("R6 R7 R8 model", gnt, mgnt);
      check("R2 onehot", N'($onehot(gnt)), N'(1));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule